// File: doc/BRIEF.md
# Reloading Countdown Timer

This block is a single free-running countdown timer with a programmable 28-bit reload value. Software reaches it through a 32-bit register port that has two words. The first is a control/status word. It holds the interrupt flag, a spare reload-request bit, the interrupt enable, the run enable and the reload value. The second is an acknowledge word that is write-only in effect. A one-cycle `tick_en` strobe is the time base; it is normally a prescaled reference of about 38.4 MHz. The count moves only on cycles where that strobe is high.

Writing the control word with the run enable set loads the counter from the reload value. The counter then steps down once per tick. On the tick that ends a period, the flag is set and the counter starts the next period from the reload value, so expiries repeat every N ticks. Through the acknowledge word, software can clear the flag and can restart the current period. It can do one, the other, or both. The interrupt request is the flag gated by the interrupt enable. Steering it to a core is left to the surrounding logic.

A small state machine tracks the counter. `ST_IDLE` means stopped. `ST_RUN` means enabled with a non-zero reload. `ST_STALL` means enabled with a zero reload, which never expires. A control write moves it between these states:
- IDLE/RUN/STALL → IDLE when the run enable is written 0.
- any → STALL when the run enable is written 1 with a zero reload value.
- any → RUN when the run enable is written 1 with a non-zero reload value.

Top module: `lcl_reload_timer`

## Requirements
- R1: After reset the control word reads 0, `irq` is 0 and the counter is stopped, so ticks do not set the flag.
- R2: A control write at offset 0x34 stores all 32 bits, and the word reads back as written. Bit 31 is the flag, bit 30 the reload-request bit, bit 29 the interrupt enable, bit 28 the run enable and bits [27:0] the reload value N.
- R3: After a control write with bit 28 set and N > 0, the flag rises on the N-th tick after the write. A tick in the write cycle itself is not counted.
- R4: On expiry the counter reloads N, so while enabled the flag is set again every N ticks.
- R5: A control write with bit 28 clear stops the counter; no later tick sets the flag.
- R6: A write at offset 0x38 with bit 31 set clears the flag. Acknowledge bits other than 31 and 30 have no effect. Reading offset 0x38 returns 0.
- R7: An acknowledge write with bit 30 set restarts the period from N when bit 28 is set. It has no effect while the timer is stopped.
- R8: With bit 28 set and N = 0, the timer never expires, and a restart does not change that.
- R9: `irq` is high exactly when the flag (bit 31) and the interrupt enable (bit 29) are both 1.
- R10: If an expiry and a flag-clearing acknowledge fall in the same cycle, the flag ends set.
- R11: Cycles with `tick_en` low do not advance the count. Writes to any other offset change nothing, and reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle count strobe from the reference prescaler |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request, flag AND interrupt enable |

## Verification
The bench builds the block with its default parameters: a 28-bit reload field, an 8-bit offset and the offsets 0x34 and 0x38. Full-width write and readback therefore cover the real field layout. The reload values are kept to a few ticks, so every state, repeated expiry, restart, stall at zero and same-cycle expiry/acknowledge collision is reached within some hundred cycles. A behavioural model compares the read data and `irq` every cycle.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

    localparam int REG_W    = 32;
    localparam int FLAG_BIT = 31;
    localparam int RLD_BIT  = 30;
    localparam int IE_BIT   = 29;
    localparam int EN_BIT   = 28;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_STALL = 2'd2
    } lrt_state_e;

endpackage

// File: rtl/lrt_core.sv
module lrt_core
    import lrt_pkg::*;
#(
    parameter int VAL_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load_req,
    input  logic             load_en,
    input  logic [VAL_W-1:0] load_val,
    input  logic [VAL_W-1:0] cur_val,
    input  logic             restart_req,
    output logic             expire
);

    localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

    lrt_state_e       state_q, state_d;
    logic [VAL_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        if (load_req) begin
            cnt_d = load_val;
            if (!load_en)
                state_d = ST_IDLE;
            else if (load_val == '0)
                state_d = ST_STALL;
            else
                state_d = ST_RUN;
        end else if (restart_req) begin
            cnt_d = cur_val;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (tick_en) begin
                        if (cnt_q == ONE) begin
                            expire = 1'b1;
                            cnt_d  = cur_val;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                ST_IDLE, ST_STALL: begin
                    cnt_d = cnt_q;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // R3: a running count is never zero and never above the reload value
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q != '0 && cnt_q <= cur_val));

    // R4: the period after an expiry starts from the reload value
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == $past(cur_val)));

    // R5: no expiry unless running
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> !expire);

    // R8: the stall state only holds with a zero reload value
    p_zero_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL) |-> (cur_val == '0));

endmodule

// File: rtl/lrt_regs.sv
module lrt_regs
    import lrt_pkg::*;
#(
    parameter int          VAL_W    = 28,
    parameter int          ADDR_W   = 8,
    parameter int unsigned CTRL_OFS = 'h34,
    parameter int unsigned ACK_OFS  = 'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              expire,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              ctrl_wr,
    output logic              restart_req,
    output logic [VAL_W-1:0]  val_q,
    output logic              flag_q,
    output logic              ie_q
);

    logic ack_wr;
    logic rld_q;
    logic en_q;

    assign ctrl_wr     = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));
    assign ack_wr      = reg_wr && (reg_addr == ADDR_W'(ACK_OFS));
    assign restart_req = ack_wr && reg_wdata[RLD_BIT] && en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            rld_q  <= 1'b0;
            ie_q   <= 1'b0;
            en_q   <= 1'b0;
            val_q  <= '0;
        end else if (ctrl_wr) begin
            flag_q <= reg_wdata[FLAG_BIT];
            rld_q  <= reg_wdata[RLD_BIT];
            ie_q   <= reg_wdata[IE_BIT];
            en_q   <= reg_wdata[EN_BIT];
            val_q  <= reg_wdata[VAL_W-1:0];
        end else begin
            if (ack_wr && reg_wdata[FLAG_BIT])
                flag_q <= 1'b0;
            if (expire)
                flag_q <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(CTRL_OFS)) begin
            reg_rdata            = REG_W'(val_q);
            reg_rdata[FLAG_BIT]  = flag_q;
            reg_rdata[RLD_BIT]   = rld_q;
            reg_rdata[IE_BIT]    = ie_q;
            reg_rdata[EN_BIT]    = en_q;
        end
    end

    // R6: a clearing acknowledge without a colliding expiry drops the flag
    p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && reg_wdata[FLAG_BIT] && !expire) |=> !flag_q);

    // R10: an expiry always leaves the flag set
    p_expiry_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_q);

    // R7: no restart request while the timer is stopped
    p_restart_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q) |-> !restart_req);

endmodule

// File: rtl/lcl_reload_timer.sv
module lcl_reload_timer
    import lrt_pkg::*;
#(
    parameter int          VAL_W    = 28,
    parameter int          ADDR_W   = 8,
    parameter int unsigned CTRL_OFS = 'h34,
    parameter int unsigned ACK_OFS  = 'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);

    logic             expire;
    logic             ctrl_wr;
    logic             restart_req;
    logic [VAL_W-1:0] val_q;
    logic             flag_q;
    logic             ie_q;

    lrt_regs #(
        .VAL_W    (VAL_W),
        .ADDR_W   (ADDR_W),
        .CTRL_OFS (CTRL_OFS),
        .ACK_OFS  (ACK_OFS)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .expire      (expire),
        .reg_rdata   (reg_rdata),
        .ctrl_wr     (ctrl_wr),
        .restart_req (restart_req),
        .val_q       (val_q),
        .flag_q      (flag_q),
        .ie_q        (ie_q)
    );

    lrt_core #(
        .VAL_W (VAL_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .load_req    (ctrl_wr),
        .load_en     (reg_wdata[EN_BIT]),
        .load_val    (reg_wdata[VAL_W-1:0]),
        .cur_val     (val_q),
        .restart_req (restart_req),
        .expire      (expire)
    );

    assign irq = flag_q & ie_q;

    // R6: the acknowledge word always reads as zero
    p_ack_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(ACK_OFS)) |-> (reg_rdata == '0));

    // R9: a request only leaves with the enable bit visible in the control word
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && reg_addr == ADDR_W'(CTRL_OFS)) |-> (reg_rdata[IE_BIT] && reg_rdata[FLAG_BIT]));

endmodule

// File: tb/test_lcl_reload_timer.sv
module test_lcl_reload_timer;

    localparam int PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'h34;
    localparam logic [7:0] A_ACK  = 8'h38;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h34;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // behavioural reference state
    bit          m_flag, m_rld, m_ie, m_en;
    logic [27:0] m_val;
    int          m_cnt;

    lcl_reload_timer i_lcl_reload_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // reference model, updated on each rising edge from the inputs held there
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flag = 0; m_rld = 0; m_ie = 0; m_en = 0; m_val = '0; m_cnt = 0;
        end else begin
            bit fire;
            fire = 0;
            if (reg_wr && reg_addr == A_CTRL) begin
                m_flag = reg_wdata[31]; m_rld = reg_wdata[30];
                m_ie = reg_wdata[29]; m_en = reg_wdata[28];
                m_val = reg_wdata[27:0];
                m_cnt = int'(reg_wdata[27:0]);
            end else begin
                if (reg_wr && reg_addr == A_ACK && reg_wdata[30] && m_en)
                    m_cnt = int'(m_val);
                else if (m_en && m_val != 0 && tick_en) begin
                    if (m_cnt == 1) begin
                        fire = 1;
                        m_cnt = int'(m_val);
                    end else
                        m_cnt = m_cnt - 1;
                end
                if (reg_wr && reg_addr == A_ACK && reg_wdata[31]) m_flag = 0;
                if (fire) m_flag = 1;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] exp_rd;
            exp_rd = (reg_addr == A_CTRL) ? {m_flag, m_rld, m_ie, m_en, m_val} : 32'h0;
            check(reg_rdata == exp_rd, "R2/R11 model read data", reg_rdata, exp_rd);
            check(irq == (m_flag & m_ie), "R9 model irq", {31'b0, irq}, {31'b0, m_flag & m_ie});
        end
    end

    task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d, input bit tk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; tick_en = tk;
        @(posedge clk); #1;
        reg_wr = 0; tick_en = 0; reg_addr = A_CTRL; reg_wdata = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(0, A_CTRL, '0, 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, A_CTRL, '0, 0);
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        reg_addr = a; #1;
        check(reg_rdata === e, tag, reg_rdata, e);
        reg_addr = A_CTRL;
    endtask

    task automatic expect_irq(input bit e, input string tag);
        check(irq === e, tag, {31'b0, irq}, {31'b0, e});
    endtask

    initial begin
        #(PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state and stopped counter
        expect_rd(A_CTRL, 32'h0, "R1 reset control word");
        expect_irq(0, "R1 reset irq");
        ticks(5);
        expect_rd(A_CTRL, 32'h0, "R1 ticks ignored after reset");

        // R2, R3: start with N=3
        step(1, A_CTRL, 32'h3000_0003, 1);
        expect_rd(A_CTRL, 32'h3000_0003, "R2 readback");
        ticks(2);
        expect_rd(A_CTRL, 32'h3000_0003, "R3 before Nth tick");
        ticks(1);
        expect_rd(A_CTRL, 32'hB000_0003, "R3 flag on Nth tick");
        expect_irq(1, "R9 irq with enable");

        // R6 clear, R4 auto reload
        step(1, A_ACK, 32'h8000_0000, 0);
        expect_rd(A_CTRL, 32'h3000_0003, "R6 flag cleared");
        expect_rd(A_ACK, 32'h0, "R6 ack reads zero");
        ticks(2);
        expect_rd(A_CTRL, 32'h3000_0003, "R4 mid period");
        ticks(1);
        expect_rd(A_CTRL, 32'hB000_0003, "R4 second expiry");

        // R11: no tick, no progress
        step(1, A_ACK, 32'h8000_0000, 0);
        idle(10);
        expect_rd(A_CTRL, 32'h3000_0003, "R11 idle cycles");
        ticks(2);
        expect_rd(A_CTRL, 32'h3000_0003, "R11 count resumes");
        ticks(1);
        expect_rd(A_CTRL, 32'hB000_0003, "R11 expiry after idle");

        // R7: restart while enabled
        step(1, A_ACK, 32'h8000_0000, 0);
        ticks(2);
        step(1, A_ACK, 32'h4000_0000, 0);
        ticks(2);
        expect_rd(A_CTRL, 32'h3000_0003, "R7 restart delays expiry");
        ticks(1);
        expect_rd(A_CTRL, 32'hB000_0003, "R7 expiry after restart");

        // R9: flag without interrupt enable
        step(1, A_CTRL, 32'h1000_0002, 0);
        expect_rd(A_CTRL, 32'h1000_0002, "R2 rewrite");
        ticks(2);
        expect_rd(A_CTRL, 32'h9000_0002, "R9 flag set");
        expect_irq(0, "R9 irq masked");

        // R10: expiry and clear collide
        step(1, A_ACK, 32'h8000_0000, 0);
        expect_rd(A_CTRL, 32'h1000_0002, "R10 clear first");
        ticks(1);
        step(1, A_ACK, 32'h8000_0000, 1);
        expect_rd(A_CTRL, 32'h9000_0002, "R10 expiry wins");

        // R5: disable stops; R7 restart ignored while stopped
        step(1, A_CTRL, 32'h2000_0002, 0);
        ticks(10);
        expect_rd(A_CTRL, 32'h2000_0002, "R5 stopped");
        expect_irq(0, "R5 no irq");
        step(1, A_ACK, 32'h4000_0000, 0);
        ticks(5);
        expect_rd(A_CTRL, 32'h2000_0002, "R7 no restart when stopped");

        // R8: zero reload never expires
        step(1, A_CTRL, 32'h3000_0000, 0);
        ticks(20);
        expect_rd(A_CTRL, 32'h3000_0000, "R8 zero reload");
        step(1, A_ACK, 32'h4000_0000, 1);
        ticks(5);
        expect_rd(A_CTRL, 32'h3000_0000, "R8 zero reload after restart");

        // R11: unknown offset
        step(1, 8'h40, 32'hFFFF_FFFF, 1);
        expect_rd(A_CTRL, 32'h3000_0000, "R11 stray write ignored");
        expect_rd(8'h40, 32'h0, "R11 stray read zero");

        // R6: other acknowledge bits ignored
        step(1, A_CTRL, 32'h3000_0004, 0);
        ticks(4);
        expect_rd(A_CTRL, 32'hB000_0004, "R3 N=4 expiry");
        step(1, A_ACK, 32'h3FFF_FFFF, 0);
        expect_rd(A_CTRL, 32'hB000_0004, "R6 other ack bits ignored");
        expect_irq(1, "R9 irq held");

        idle(2);
        finish_run();
    end

endmodule